// File: doc/BRIEF.md
# Serial Memory Slave Protocol Engine

This block is the bus-facing half of a 4096-byte serial memory. It runs on a fast system clock, oversamples the two-wire bus lines (clock and data), and cleans them up before use. It decodes start and stop conditions, receives and sends bytes most significant bit first, and answers each byte on the ninth bus clock. Its data output is open-drain: the port `sda_oe_o` pulls the data line low when it is 1.

A transfer opens with a command byte. The upper nibble is the fixed tag 1010, bits 3..1 select the device and must equal the strap pins, and bit 0 chooses write (0) or read (1). A write command is followed by two address bytes and then by data bytes. Each data byte is handed to an external page buffer together with its address. A stop after at least one data byte asks an external programming timer to start. A read command streams bytes from the external array, beginning at the internal 12-bit address counter. A repeated start after the address bytes turns a write into a random read.

While the external programming cycle is busy, the block does not acknowledge command bytes. This lets a host poll for completion. A write-protect pin blocks the programming request.

Top module: `serial_mem_slave`

## Requirements
- R1: After synchronous reset the data line is released, no write strobe or programming request is asserted, and the address counter reads 0x000.
- R2: The data-line output changes only after a falling edge of the bus clock has been seen (or after a start or stop), never in the middle of a bus-clock high phase.
- R3: A command byte whose bits 7..4 are 1010 and whose bits 3..1 equal the strap pins is acknowledged on the ninth clock. Any other command byte is left unacknowledged, and the block then ignores the bus (no acknowledge, no strobe) until the next start.
- R4: After a write command, bits 3..0 of the first address byte become counter bits 11..8 and the second address byte becomes bits 7..0. Both bytes are acknowledged.
- R5: Each data byte of a write is acknowledged and presented for one clock on the write-strobe port with the counter value as its address. After each byte only counter bits 4..0 increment, so the address wraps inside the 32-byte page.
- R6: A stop that follows at least one write data byte produces exactly one programming-start pulse, and the counter is then set back to the address of the last data byte entered.
- R7: While the write-protect pin is high, no programming-start pulse is produced.
- R8: While the programming-busy input is high, neither a read nor a write command byte is acknowledged, and the rest of that transfer is ignored.
- R9: A read command sends the byte at the counter, MSB first, and increments the full 12-bit counter once per byte sent, wrapping from 0xFFF to 0x000. Combined with a preceding write command and address bytes ended by a repeated start, this gives a random read.
- R10: A read command without preceding address bytes starts at the current counter value.
- R11: An acknowledge from the host after a read byte makes the block send the next byte. No acknowledge makes it release the data line and send nothing more until the next start.
- R12: A repeated start after write data bytes cancels the programming request for that transfer; only a stop in the data phase produces one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull the data line low (open-drain) |
| chip_sel_i | input | 3 | Strap pins compared with command bits 3..1 |
| wp_i | input | 1 | Write protect; 1 blocks programming requests |
| prog_busy_i | input | 1 | External programming cycle in progress |
| rd_addr_o | output | ADDR_W | Address counter, used as read address |
| rd_data_i | input | 8 | Array byte at rd_addr_o |
| wr_stb_o | output | 1 | One-clock strobe for a received write byte |
| wr_addr_o | output | ADDR_W | Address of the strobed byte |
| wr_data_o | output | 8 | Value of the strobed byte |
| prog_start_o | output | 1 | One-clock request to start programming |

## Verification
Command bytes are sent with a wrong strap field, with a wrong tag, with programming busy, and with a good match. This separates the acknowledge decision from the ignore-until-start behaviour. Writes starting mid-page and just below a page end show whether the counter increments within the page or across the whole array. Reads that begin at the top of the array and at an arbitrary address show the full-width wrap and the random versus current-address start. Transfers ended by stop, by repeated start, and under write protect show exactly when a programming request is issued. A host no-acknowledge placed just before a byte whose MSB is 0 exposes any data the block drives after it should have let go of the line.

// File: rtl/sms_pkg.sv
package sms_pkg;
  localparam logic [3:0] DEV_TAG = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } sms_state_e;
endpackage

// File: rtl/sms_line_filter.sv
module sms_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int HALF = FILT_TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_TAPS-1:0]   win_q;
  logic                   filt_q;

  function automatic logic majority(input logic [FILT_TAPS-1:0] w);
    int ones;
    ones = 0;
    for (int i = 0; i < FILT_TAPS; i++) ones += int'(w[i]);
    return ones > HALF;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      win_q  <= '1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      win_q  <= {win_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      filt_q <= majority(win_q);
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/sms_bus_events.sv
module sms_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  assign start_o    = scl_q & scl_f_i & sda_q & ~sda_f_i;
  assign stop_o     = scl_q & scl_f_i & ~sda_q & sda_f_i;
  assign scl_rise_o = ~scl_q & scl_f_i;
  assign scl_fall_o = scl_q & ~scl_f_i;

  // R2: bus conditions are mutually exclusive events
  assert_events_excl_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));

  // R2: a start or stop is only seen while the clock line stays high
  assert_cond_scl_high_R2: assert property (@(posedge clk) disable iff (rst)
    (start_o || stop_o) |-> (scl_f_i && $past(scl_f_i)));
endmodule

// File: rtl/sms_proto_fsm.sv
module sms_proto_fsm
  import sms_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic [2:0]        chip_sel_i,
  input  logic              wp_i,
  input  logic              prog_busy_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              prog_start_o
);
  localparam int HI_W = ADDR_W - 8;

  sms_state_e        st;
  logic [3:0]        cnt;
  logic              in_ack;
  logic              m_nack;
  logic              wrote;
  logic [7:0]        sh_in;
  logic [7:0]        sh_out;
  logic              oe_q;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] last_q;
  logic              wr_stb_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [7:0]        wr_data_q;
  logic              prog_q;
  logic              dev_hit;

  assign dev_hit = (sh_in[7:4] == DEV_TAG) && (sh_in[3:1] == chip_sel_i) && !prog_busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      in_ack    <= 1'b0;
      m_nack    <= 1'b0;
      wrote     <= 1'b0;
      sh_in     <= '0;
      sh_out    <= '0;
      oe_q      <= 1'b0;
      hi_q      <= '0;
      addr_q    <= '0;
      last_q    <= '0;
      wr_stb_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      prog_q    <= 1'b0;
    end else begin
      wr_stb_q <= 1'b0;
      prog_q   <= 1'b0;
      if (start_i) begin
        st     <= ST_DEVSEL;
        cnt    <= '0;
        in_ack <= 1'b0;
        oe_q   <= 1'b0;
        wrote  <= 1'b0;
      end else if (stop_i) begin
        if (st == ST_WDATA && wrote) begin
          prog_q <= !wp_i;
          addr_q <= last_q;
        end
        st     <= ST_IDLE;
        cnt    <= '0;
        in_ack <= 1'b0;
        oe_q   <= 1'b0;
        wrote  <= 1'b0;
      end else if (st != ST_IDLE && st != ST_IGNORE) begin
        if (scl_rise_i) begin
          if (in_ack) begin
            m_nack <= sda_i;
          end else if (cnt < 4'd8) begin
            sh_in <= {sh_in[6:0], sda_i};
            cnt   <= cnt + 4'd1;
          end
        end else if (scl_fall_i) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            cnt    <= '0;
            oe_q   <= 1'b0;
            if (st == ST_RDATA) begin
              if (m_nack) begin
                st <= ST_IGNORE;
              end else begin
                sh_out <= rd_data_i;
                oe_q   <= !rd_data_i[7];
              end
            end
          end else if (cnt == 4'd8) begin
            in_ack <= 1'b1;
            case (st)
              ST_DEVSEL: begin
                if (dev_hit) begin
                  oe_q <= 1'b1;
                  st   <= sh_in[0] ? ST_RDATA : ST_AHI;
                end else begin
                  oe_q <= 1'b0;
                  st   <= ST_IGNORE;
                end
              end
              ST_AHI: begin
                oe_q <= 1'b1;
                hi_q <= sh_in[HI_W-1:0];
                st   <= ST_ALO;
              end
              ST_ALO: begin
                oe_q   <= 1'b1;
                addr_q <= {hi_q, sh_in};
                st     <= ST_WDATA;
              end
              ST_WDATA: begin
                oe_q      <= 1'b1;
                wr_stb_q  <= 1'b1;
                wr_addr_q <= addr_q;
                wr_data_q <= sh_in;
                last_q    <= addr_q;
                wrote     <= 1'b1;
                addr_q    <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
              end
              ST_RDATA: begin
                oe_q   <= 1'b0;
                addr_q <= addr_q + 1'b1;
              end
              default: oe_q <= 1'b0;
            endcase
          end else if (st == ST_RDATA && cnt != 4'd0) begin
            sh_out <= {sh_out[6:0], 1'b0};
            oe_q   <= !sh_out[6];
          end
        end
      end
    end
  end

  assign sda_oe_o     = oe_q;
  assign addr_o       = addr_q;
  assign wr_stb_o     = wr_stb_q;
  assign wr_addr_o    = wr_addr_q;
  assign wr_data_o    = wr_data_q;
  assign prog_start_o = prog_q;

  // R2: the data output moves only on a clock fall, start or stop
  assert_oe_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(oe_q) |-> ($past(scl_fall_i) || $past(start_i) || $past(stop_i)));

  // R3: an ignored transfer never pulls the data line
  assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IGNORE) |-> !oe_q);

  // R5: the write counter stays inside the page of the strobed byte
  assert_page_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    wr_stb_q |-> ((addr_q[ADDR_W-1:PAGE_W] == wr_addr_q[ADDR_W-1:PAGE_W]) &&
                  (addr_q[PAGE_W-1:0] == wr_addr_q[PAGE_W-1:0] + 1'b1)));

  // R7: a programming request follows a stop with protection off
  assert_prog_gate_R7: assert property (@(posedge clk) disable iff (rst)
    prog_q |-> ($past(stop_i) && !$past(wp_i)));

  // R8: no command acknowledge while programming is busy
  assert_busy_nack_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(in_ack) && $past(st) == ST_DEVSEL && $past(prog_busy_i)) |-> !oe_q);
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        chip_sel_i,
  input  logic              wp_i,
  input  logic              prog_busy_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              prog_start_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] filt;
  logic start, stop, scl_rise, scl_fall;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    sms_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_TAPS  (FILT_TAPS)
    ) u_filt (
      .clk   (clk),
      .rst   (rst),
      .raw_i (raw[g]),
      .filt_o(filt[g])
    );
  end

  sms_bus_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl_f_i   (filt[1]),
    .sda_f_i   (filt[0]),
    .start_o   (start),
    .stop_o    (stop),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  sms_proto_fsm #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .stop_i      (stop),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .sda_i       (filt[0]),
    .chip_sel_i  (chip_sel_i),
    .wp_i        (wp_i),
    .prog_busy_i (prog_busy_i),
    .rd_data_i   (rd_data_i),
    .sda_oe_o    (sda_oe_o),
    .addr_o      (rd_addr_o),
    .wr_stb_o    (wr_stb_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .prog_start_o(prog_start_o)
  );
endmodule

// File: tb/serial_mem_slave_tb_top.sv
module serial_mem_slave_tb_top;
  localparam int AW = 12;
  localparam int Q  = 20;
  localparam logic [2:0] CSEL  = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, CSEL, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, CSEL, 1'b1};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic busy = 1'b0;
  logic sda_oe, wr_stb, prog_start;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0] wr_data, rd_data;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  function automatic logic [7:0] mem_val(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  assign rd_data = mem_val(int'(rd_addr));

  serial_mem_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .chip_sel_i(CSEL), .wp_i(wp), .prog_busy_i(busy), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .prog_start_o(prog_start)
  );

  int errs = 0;
  int checks = 0;
  int prog_cnt = 0;
  int oe_viol = 0;
  int scl_age = 0;
  logic prev_oe = 1'b0;
  logic prev_scl = 1'b1;
  bit done = 1'b0;
  int exp_wa[$];
  int exp_wd[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock reference comparison: write strobes, programming pulses,
  // and the rule that the data output holds while the clock line is high.
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_stb) begin
        if (exp_wa.size() == 0) begin
          chk(1'b0, "R5 unexpected write strobe", int'(wr_addr), -1);
        end else begin
          chk(int'(wr_addr) == exp_wa[0], "R5 write address", int'(wr_addr), exp_wa[0]);
          chk(int'(wr_data) == exp_wd[0], "R5 write data", int'(wr_data), exp_wd[0]);
          void'(exp_wa.pop_front());
          void'(exp_wd.pop_front());
        end
      end
      if (prog_start) prog_cnt++;
      if (scl_m != prev_scl) scl_age = 0; else scl_age++;
      if (scl_m && scl_age > 12 && sda_oe != prev_oe) begin
        oe_viol++;
        $display("FAIL R2: actual=oe change in clock-high phase expected=stable");
      end
      prev_scl = scl_m;
      prev_oe  = sda_oe;
    end
  end

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b1; qw();
    qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw();
      scl_m = 1'b1; qw(); qw();
      scl_m = 1'b0; qw();
    end
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    acked = !sda_bus; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw();
      scl_m = 1'b1; qw();
      d[i] = sda_bus; qw();
      scl_m = 1'b0;
    end
    qw();
    sda_m = !ack; qw();
    scl_m = 1'b1; qw(); qw();
    scl_m = 1'b0; qw();
    sda_m = 1'b1;
  endtask

  task automatic set_addr(input int a, input string req);
    logic k;
    bus_start();
    send_byte(DEV_W, k);     chk(k, req, int'(k), 1);
    send_byte(8'(a >> 8), k); chk(k, "R4 high address ack", int'(k), 1);
    send_byte(8'(a), k);      chk(k, "R4 low address ack", int'(k), 1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic k;
    logic [7:0] d;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 data released", int'(sda_oe), 0);
    chk(wr_stb == 1'b0 && prog_start == 1'b0, "R1 no strobes", int'({wr_stb, prog_start}), 0);
    chk(rd_addr == '0, "R1 counter zero", int'(rd_addr), 0);

    // R3 strap mismatch, then ignored data byte
    bus_start();
    send_byte({4'b1010, 3'b011, 1'b0}, k); chk(!k, "R3 strap mismatch nack", int'(k), 0);
    send_byte(8'h55, k);                   chk(!k, "R3 ignored until start", int'(k), 0);
    bus_stop();
    // R3 tag mismatch
    bus_start();
    send_byte({4'b1011, CSEL, 1'b0}, k);   chk(!k, "R3 tag mismatch nack", int'(k), 0);
    bus_stop();
    chk(prog_cnt == 0, "R3 no programming", prog_cnt, 0);

    // R4 R5 R6 plain write
    set_addr('h123, "R3 select ack");
    exp_wa.push_back('h123); exp_wd.push_back('hA1);
    exp_wa.push_back('h124); exp_wd.push_back('hB2);
    exp_wa.push_back('h125); exp_wd.push_back('hC3);
    send_byte(8'hA1, k); chk(k, "R5 data ack", int'(k), 1);
    send_byte(8'hB2, k); chk(k, "R5 data ack", int'(k), 1);
    send_byte(8'hC3, k); chk(k, "R5 data ack", int'(k), 1);
    bus_stop();
    chk(exp_wa.size() == 0, "R5 all strobes seen", exp_wa.size(), 0);
    chk(prog_cnt == 1, "R6 one programming pulse", prog_cnt, 1);
    chk(rd_addr == 12'h125, "R6 counter at last byte", int'(rd_addr), 'h125);

    // R5 page wrap
    set_addr('h05E, "R3 select ack");
    exp_wa.push_back('h05E); exp_wd.push_back('h11);
    exp_wa.push_back('h05F); exp_wd.push_back('h22);
    exp_wa.push_back('h040); exp_wd.push_back('h33);
    exp_wa.push_back('h041); exp_wd.push_back('h44);
    send_byte(8'h11, k); send_byte(8'h22, k); send_byte(8'h33, k); send_byte(8'h44, k);
    bus_stop();
    chk(exp_wa.size() == 0, "R5 page wrap strobes", exp_wa.size(), 0);
    chk(prog_cnt == 2, "R6 programming after wrap", prog_cnt, 2);
    chk(rd_addr == 12'h041, "R5 counter wrapped in page", int'(rd_addr), 'h041);

    // R7 write protect
    wp = 1'b1;
    set_addr('h300, "R3 select ack");
    exp_wa.push_back('h300); exp_wd.push_back('h5A);
    send_byte(8'h5A, k);
    bus_stop();
    chk(prog_cnt == 2, "R7 protected, no programming", prog_cnt, 2);
    wp = 1'b0;

    // R12 repeated start cancels programming
    set_addr('h310, "R3 select ack");
    exp_wa.push_back('h310); exp_wd.push_back('h66);
    send_byte(8'h66, k);
    bus_start();
    send_byte(DEV_W, k);
    bus_stop();
    chk(prog_cnt == 2, "R12 repeated start, no programming", prog_cnt, 2);

    // R8 busy polling
    busy = 1'b1;
    bus_start();
    send_byte(DEV_W, k); chk(!k, "R8 busy write nack", int'(k), 0);
    send_byte(8'h00, k); chk(!k, "R8 busy rest ignored", int'(k), 0);
    bus_stop();
    bus_start();
    send_byte(DEV_R, k); chk(!k, "R8 busy read nack", int'(k), 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(DEV_W, k); chk(k, "R8 ack after busy", int'(k), 1);
    bus_stop();

    // R9 R11 random read
    set_addr('h200, "R3 select ack");
    bus_start();
    send_byte(DEV_R, k); chk(k, "R9 read select ack", int'(k), 1);
    recv_byte(1'b1, d); chk(d == mem_val('h200), "R9 random read byte0", int'(d), int'(mem_val('h200)));
    recv_byte(1'b1, d); chk(d == mem_val('h201), "R11 continue byte1", int'(d), int'(mem_val('h201)));
    recv_byte(1'b0, d); chk(d == mem_val('h202), "R11 last byte", int'(d), int'(mem_val('h202)));
    qw();
    chk(sda_oe == 1'b0, "R11 released after nack", int'(sda_oe), 0);
    bus_stop();
    chk(rd_addr == 12'h203, "R9 counter after read", int'(rd_addr), 'h203);

    // R10 current address read
    bus_start();
    send_byte(DEV_R, k); chk(k, "R10 read select ack", int'(k), 1);
    recv_byte(1'b0, d); chk(d == mem_val('h203), "R10 current address", int'(d), int'(mem_val('h203)));
    bus_stop();
    chk(rd_addr == 12'h204, "R10 counter advanced", int'(rd_addr), 'h204);

    // R9 full-array wrap
    set_addr('hFFE, "R3 select ack");
    bus_start();
    send_byte(DEV_R, k);
    recv_byte(1'b1, d); chk(d == mem_val('hFFE), "R9 byte FFE", int'(d), int'(mem_val('hFFE)));
    recv_byte(1'b1, d); chk(d == mem_val('hFFF), "R9 byte FFF", int'(d), int'(mem_val('hFFF)));
    recv_byte(1'b0, d); chk(d == mem_val(0), "R9 wrap to 000", int'(d), int'(mem_val(0)));
    bus_stop();
    chk(rd_addr == 12'h001, "R9 counter after wrap", int'(rd_addr), 1);

    chk(oe_viol == 0, "R2 output stable in clock-high", oe_viol, 0);
    chk(exp_wa.size() == 0, "R5 no pending strobes", exp_wa.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule